// File: doc/BRIEF.md
# Synthesizer Serial Programming Port

This block is the host-facing programming front end of a dual-loop frequency synthesizer. A host drives a serial clock, an enable line and two data lines. The block oversamples all four with a fast system clock. It shifts in serial words and, on the falling edge of the enable line, moves a finished word into one of three holding register groups: control bits, the reference-divider word, or the pair of transmit and receive channel divide ratios. The divider chains and phase detectors that use these registers sit outside the block.

The enable level during a transfer selects the target. With enable held high, the word goes to the control group or to the reference group, and its first bit tells the two apart. With enable held low and then pulsed, the word goes to the channel ratios. A control bit picks one of two channel formats. In the one-wire format, both ratios arrive in series on the main data line. In the two-wire format, both ratios arrive side by side on the two data lines, which needs half the serial clocks. A word of the wrong length is dropped, and the registers keep their old values.

The controller has four states. `ST_IDLE` waits for activity. An enable rise takes it to `ST_HI_SHIFT`. A serial clock rise while enable is low takes it to `ST_CH_SHIFT`. In `ST_CH_SHIFT`, an enable rise takes it to `ST_CH_ARMED`. In `ST_CH_ARMED`, an enable fall commits the channel word and returns to `ST_IDLE`. A serial clock rise in `ST_CH_ARMED` restarts the shift as an enable-high word and moves to `ST_HI_SHIFT`. In `ST_HI_SHIFT`, an enable fall commits a control or reference word and returns to `ST_IDLE`.

Top module: `synth_prog_port`

## Requirements
- R1: After reset the control outputs are 0, the select flags and both reference ratios are 0, and `tx_ratio` and `rx_ratio` are 16.
- R2: With enable high, an 8-bit word whose first bit is 1 updates the control outputs when enable falls. Bits arrive MSB first: identifier, a spare bit, then test, two-wire select, ref divide-by-3, tx power-down, rx power-down and ref power-down.
- R3: With enable high, a 32-bit word whose first bit is 0 updates the reference fields when enable falls. After the identifier it carries, MSB first, 5 select flags, a 12-bit reference ratio and a 14-bit auxiliary ratio.
- R4: In one-wire mode (two-wire select = 0), a 32-bit enable-low word on `ser_dat` loads `rx_ratio` from the first 16 bits and `tx_ratio` from the last 16 bits. The word takes effect when enable falls after its pulse, and `ser_aux` has no effect.
- R5: In two-wire mode (two-wire select = 1), a 16-clock enable-low word loads `rx_ratio` from `ser_dat` and `tx_ratio` from `ser_aux`, both MSB first.
- R6: A word is dropped, leaving every output unchanged, if its bit count is not the one its format needs. The counts are 8 for control, 32 for reference, 32 for one-wire channel and 16 for two-wire channel. An 8-bit word starting with 0 and a 32-bit enable-high word starting with 1 are also dropped.
- R7: A channel load leaves the control and reference outputs unchanged, and a control or reference load leaves both channel ratios unchanged.
- R8: A channel ratio below 16 is stored as 16, so both ratios never read below 16.
- R9: Outputs change only in the cycle after a synchronized enable fall. They hold steady while bits are being shifted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock from the host; data is taken on its rising edge |
| ser_en | input | 1 | Enable line; its level selects the target, and its falling edge commits |
| ser_dat | input | 1 | Main serial data line |
| ser_aux | input | 1 | Second data line, used only in two-wire channel mode |
| ctl_test | output | 1 | Test bit |
| ctl_aux_sel | output | 1 | Two-wire channel mode select |
| ctl_ref_div3 | output | 1 | Reference output divide-by-3 select |
| ctl_tx_pd | output | 1 | Transmit path power-down |
| ctl_rx_pd | output | 1 | Receive path power-down |
| ctl_ref_pd | output | 1 | Reference counters power-down |
| ref_sel | output | 5 | Reference routing and select flags |
| ref_ratio | output | 12 | Main reference divide ratio |
| aux_ratio | output | 14 | Auxiliary reference divide ratio |
| tx_ratio | output | 16 | Transmit channel divide ratio |
| rx_ratio | output | 16 | Receive channel divide ratio |

## Verification
The bench checks the reset values first. It then sends control and reference words with distinct bit patterns, so a swapped or shifted field shows up as a wrong value. Channel words are sent in one-wire mode while `ser_aux` toggles, and in two-wire mode with different values on the two lines, so a swapped ratio or a leak from the unused line is visible. Words one bit too long or too short, and words with the wrong identifier bit, show whether length checking keeps the old contents. Ratios below 16 check the clamp. A long hold of enable before its fall shows whether any output changes before the commit edge.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HI_SHIFT,
        ST_CH_SHIFT,
        ST_CH_ARMED
    } port_state_e;

    typedef struct packed {
        logic test;
        logic aux_sel;
        logic ref_div3;
        logic tx_pd;
        logic rx_pd;
        logic ref_pd;
    } ctl_bits_t;

endpackage

// File: rtl/prog_sync.sv
module prog_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [STAGES:0][W-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[STAGES-1:0], d};
        end
    end

    assign q    = pipe[STAGES-1];
    assign rise = pipe[STAGES-1] & ~pipe[STAGES];
    assign fall = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/prog_shifter.sv
module prog_shifter #(
    parameter int MAIN_W = 32,
    parameter int AUX_W  = 16,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              shift,
    input  logic              din,
    input  logic              ain,
    output logic [MAIN_W-1:0] main_q,
    output logic [AUX_W-1:0]  aux_q,
    output logic [CNT_W-1:0]  count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            main_q <= '0;
            aux_q  <= '0;
            count  <= '0;
        end else if (clear && shift) begin
            main_q <= {{(MAIN_W-1){1'b0}}, din};
            aux_q  <= {{(AUX_W-1){1'b0}}, ain};
            count  <= CNT_W'(1);
        end else if (clear) begin
            main_q <= '0;
            aux_q  <= '0;
            count  <= '0;
        end else if (shift) begin
            main_q <= {main_q[MAIN_W-2:0], din};
            aux_q  <= {aux_q[AUX_W-2:0], ain};
            if (count != CNT_MAX) begin
                count <= count + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/synth_prog_port.sv
module synth_prog_port
    import synth_prog_pkg::*;
#(
    parameter int RATIO_W   = 16,
    parameter int REF_W     = 12,
    parameter int AUX_REF_W = 14,
    parameter int SEL_W     = 5,
    parameter int CTL_LEN   = 8,
    parameter int MIN_RATIO = 16,
    parameter int SYNC_STG  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ser_clk,
    input  logic                 ser_en,
    input  logic                 ser_dat,
    input  logic                 ser_aux,
    output logic                 ctl_test,
    output logic                 ctl_aux_sel,
    output logic                 ctl_ref_div3,
    output logic                 ctl_tx_pd,
    output logic                 ctl_rx_pd,
    output logic                 ctl_ref_pd,
    output logic [SEL_W-1:0]     ref_sel,
    output logic [REF_W-1:0]     ref_ratio,
    output logic [AUX_REF_W-1:0] aux_ratio,
    output logic [RATIO_W-1:0]   tx_ratio,
    output logic [RATIO_W-1:0]   rx_ratio
);
    localparam int HI_W    = 1 + SEL_W + REF_W + AUX_REF_W;
    localparam int CH_W    = 2 * RATIO_W;
    localparam int SHIFT_W = (HI_W > CH_W) ? HI_W : CH_W;
    localparam int CNT_W   = $clog2(SHIFT_W + 2);
    localparam logic [RATIO_W-1:0] FLOOR = RATIO_W'(MIN_RATIO);

    logic [3:0] s_q, s_rise, s_fall;
    logic       clk_rise, en_rise, en_fall, en_lvl, dat_s, aux_s;

    prog_sync #(.W(4), .STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({ser_aux, ser_dat, ser_en, ser_clk}),
        .q(s_q), .rise(s_rise), .fall(s_fall)
    );

    assign clk_rise = s_rise[0];
    assign en_rise  = s_rise[1];
    assign en_fall  = s_fall[1];
    assign en_lvl   = s_q[1];
    assign dat_s    = s_q[2];
    assign aux_s    = s_q[3];

    logic                sh_clear, sh_shift;
    logic [SHIFT_W-1:0]  sh_main;
    logic [RATIO_W-1:0]  sh_aux;
    logic [CNT_W-1:0]    sh_cnt;

    prog_shifter #(.MAIN_W(SHIFT_W), .AUX_W(RATIO_W), .CNT_W(CNT_W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .clear(sh_clear), .shift(sh_shift),
        .din(dat_s), .ain(aux_s),
        .main_q(sh_main), .aux_q(sh_aux), .count(sh_cnt)
    );

    port_state_e state_q, state_d;
    logic        commit_hi, commit_ch;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        sh_clear  = 1'b0;
        sh_shift  = 1'b0;
        commit_hi = 1'b0;
        commit_ch = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (en_rise) begin
                    sh_clear = 1'b1;
                    state_d  = ST_HI_SHIFT;
                end else if (clk_rise && !en_lvl) begin
                    sh_clear = 1'b1;
                    sh_shift = 1'b1;
                    state_d  = ST_CH_SHIFT;
                end
            end
            ST_HI_SHIFT: begin
                if (en_fall) begin
                    commit_hi = 1'b1;
                    state_d   = ST_IDLE;
                end else if (clk_rise) begin
                    sh_shift = 1'b1;
                end
            end
            ST_CH_SHIFT: begin
                if (en_rise) begin
                    state_d = ST_CH_ARMED;
                end else if (clk_rise) begin
                    sh_shift = 1'b1;
                end
            end
            ST_CH_ARMED: begin
                if (en_fall) begin
                    commit_ch = 1'b1;
                    state_d   = ST_IDLE;
                end else if (clk_rise) begin
                    sh_clear = 1'b1;
                    sh_shift = 1'b1;
                    state_d  = ST_HI_SHIFT;
                end
            end
        endcase
    end

    function automatic logic [RATIO_W-1:0] floor_ratio(input logic [RATIO_W-1:0] v);
        return (v < FLOOR) ? FLOOR : v;
    endfunction

    ctl_bits_t ctl_q;
    logic      ctl_ok, ref_ok, one_ok, two_ok;

    assign ctl_ok = (sh_cnt == CNT_W'(CTL_LEN)) && sh_main[CTL_LEN-1];
    assign ref_ok = (sh_cnt == CNT_W'(HI_W)) && !sh_main[HI_W-1];
    assign one_ok = !ctl_q.aux_sel && (sh_cnt == CNT_W'(CH_W));
    assign two_ok = ctl_q.aux_sel && (sh_cnt == CNT_W'(RATIO_W));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q     <= '0;
            ref_sel   <= '0;
            ref_ratio <= '0;
            aux_ratio <= '0;
            tx_ratio  <= FLOOR;
            rx_ratio  <= FLOOR;
        end else if (commit_hi) begin
            if (ctl_ok) begin
                ctl_q <= ctl_bits_t'(sh_main[$bits(ctl_bits_t)-1:0]);
            end else if (ref_ok) begin
                ref_sel   <= sh_main[HI_W-2 -: SEL_W];
                ref_ratio <= sh_main[REF_W+AUX_REF_W-1 -: REF_W];
                aux_ratio <= sh_main[AUX_REF_W-1:0];
            end
        end else if (commit_ch) begin
            if (one_ok) begin
                rx_ratio <= floor_ratio(sh_main[CH_W-1 -: RATIO_W]);
                tx_ratio <= floor_ratio(sh_main[RATIO_W-1:0]);
            end else if (two_ok) begin
                rx_ratio <= floor_ratio(sh_main[RATIO_W-1:0]);
                tx_ratio <= floor_ratio(sh_aux);
            end
        end
    end

    assign ctl_test     = ctl_q.test;
    assign ctl_aux_sel  = ctl_q.aux_sel;
    assign ctl_ref_div3 = ctl_q.ref_div3;
    assign ctl_tx_pd    = ctl_q.tx_pd;
    assign ctl_rx_pd    = ctl_q.rx_pd;
    assign ctl_ref_pd   = ctl_q.ref_pd;
endmodule

// File: rtl/synth_prog_port_chk.sv
module synth_prog_port_chk #(
    parameter int RATIO_W   = 16,
    parameter int MIN_RATIO = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               en_fall,
    input logic [5:0]         ctl_vec,
    input logic [30:0]        ref_vec,
    input logic [RATIO_W-1:0] tx_ratio,
    input logic [RATIO_W-1:0] rx_ratio
);
    assert_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (tx_ratio == RATIO_W'(MIN_RATIO) && rx_ratio == RATIO_W'(MIN_RATIO)
                          && ctl_vec == '0 && ref_vec == '0));

    assert_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ratio >= RATIO_W'(MIN_RATIO)) && (rx_ratio >= RATIO_W'(MIN_RATIO)));

    assert_commit_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({ctl_vec, ref_vec, tx_ratio, rx_ratio}) |-> $past(en_fall));

    assert_keep_hi_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({tx_ratio, rx_ratio}) |-> $stable({ctl_vec, ref_vec}));

    assert_keep_ch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({ctl_vec, ref_vec}) |-> $stable({tx_ratio, rx_ratio}));
endmodule

bind synth_prog_port synth_prog_port_chk #(.RATIO_W(RATIO_W), .MIN_RATIO(MIN_RATIO)) u_chk (
    .clk(clk), .rst_n(rst_n), .en_fall(en_fall),
    .ctl_vec({ctl_test, ctl_aux_sel, ctl_ref_div3, ctl_tx_pd, ctl_rx_pd, ctl_ref_pd}),
    .ref_vec({ref_sel, ref_ratio, aux_ratio}),
    .tx_ratio(tx_ratio), .rx_ratio(rx_ratio)
);

// File: tb/sim_synth_prog_port.sv
`timescale 1ns/1ps
module sim_synth_prog_port;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_en = 1'b0, ser_dat = 1'b0, ser_aux = 1'b0;
    logic ctl_test, ctl_aux_sel, ctl_ref_div3, ctl_tx_pd, ctl_rx_pd, ctl_ref_pd;
    logic [4:0]  ref_sel;
    logic [11:0] ref_ratio;
    logic [13:0] aux_ratio;
    logic [15:0] tx_ratio, rx_ratio;

    always #2 clk = ~clk;

    synth_prog_port u0 (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_en(ser_en),
        .ser_dat(ser_dat), .ser_aux(ser_aux),
        .ctl_test(ctl_test), .ctl_aux_sel(ctl_aux_sel), .ctl_ref_div3(ctl_ref_div3),
        .ctl_tx_pd(ctl_tx_pd), .ctl_rx_pd(ctl_rx_pd), .ctl_ref_pd(ctl_ref_pd),
        .ref_sel(ref_sel), .ref_ratio(ref_ratio), .aux_ratio(aux_ratio),
        .tx_ratio(tx_ratio), .rx_ratio(rx_ratio)
    );

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;
    string cur_req = "R1";

    // reference model state
    logic [5:0]  e_ctl = '0, p_ctl;
    logic [4:0]  e_sel = '0, p_sel;
    logic [11:0] e_ref = '0, p_ref;
    logic [13:0] e_aux = '0, p_aux;
    int          e_tx = 16, e_rx = 16, p_tx, p_rx;
    int          pend = 0;
    bit          dq[$];
    bit          aq[$];

    function automatic int field(input int first, input int len, input bit hi_line);
        int v = 0;
        for (int i = first; i < first + len; i++) v = v * 2 + (hi_line ? aq[i] : dq[i]);
        return v;
    endfunction

    function automatic int clamp16(input int v);
        return (v < 16) ? 16 : v;
    endfunction

    task automatic model_commit(input bit hi);
        int n = dq.size();
        p_ctl = e_ctl; p_sel = e_sel; p_ref = e_ref; p_aux = e_aux; p_tx = e_tx; p_rx = e_rx;
        if (hi) begin
            if (n == 8 && dq[0] == 1'b1) p_ctl = 6'(field(2, 6, 0));
            else if (n == 32 && dq[0] == 1'b0) begin
                p_sel = 5'(field(1, 5, 0));
                p_ref = 12'(field(6, 12, 0));
                p_aux = 14'(field(18, 14, 0));
            end
        end else begin
            if (e_ctl[4] == 1'b0 && n == 32) begin
                p_rx = clamp16(field(0, 16, 0));
                p_tx = clamp16(field(16, 16, 0));
            end else if (e_ctl[4] == 1'b1 && n == 16) begin
                p_rx = clamp16(field(0, 16, 0));
                p_tx = clamp16(field(0, 16, 1));
            end
        end
        pend = 3;
    endtask

    always @(posedge clk) begin
        if (pend > 0) begin
            pend = pend - 1;
            if (pend == 0) begin
                e_ctl = p_ctl; e_sel = p_sel; e_ref = p_ref; e_aux = p_aux; e_tx = p_tx; e_rx = p_rx;
            end
        end
    end

    always @(negedge clk) begin
        if (!finished) begin
            logic [5:0] a_ctl;
            a_ctl = {ctl_test, ctl_aux_sel, ctl_ref_div3, ctl_tx_pd, ctl_rx_pd, ctl_ref_pd};
            compared++;
            if (a_ctl !== e_ctl || ref_sel !== e_sel || ref_ratio !== e_ref || aux_ratio !== e_aux
                || tx_ratio !== 16'(e_tx) || rx_ratio !== 16'(e_rx)) begin
                mismatched++;
                $display("FAIL %s t=%0t actual ctl=%b sel=%b ref=%0d aux=%0d tx=%0d rx=%0d expected ctl=%b sel=%b ref=%0d aux=%0d tx=%0d rx=%0d",
                         cur_req, $time, a_ctl, ref_sel, ref_ratio, aux_ratio, tx_ratio, rx_ratio,
                         e_ctl, e_sel, e_ref, e_aux, e_tx, e_rx);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input bit d, input bit a);
        ser_dat = d; ser_aux = a;
        tick(3);
        ser_clk = 1'b1;
        dq.push_back(d); aq.push_back(a);
        tick(4);
        ser_clk = 1'b0;
        tick(3);
    endtask

    task automatic hi_frame(input logic [31:0] w, input int n, input int hold);
        dq.delete(); aq.delete();
        ser_en = 1'b1;
        tick(4);
        for (int i = n - 1; i >= 0; i--) send_bit(w[i], 1'b0);
        tick(2 + hold);
        ser_en = 1'b0;
        model_commit(1'b1);
        tick(8);
    endtask

    task automatic ch_frame(input logic [31:0] d, input logic [31:0] a, input int n);
        dq.delete(); aq.delete();
        for (int i = n - 1; i >= 0; i--) send_bit(d[i], a[i]);
        tick(2);
        ser_en = 1'b1;
        tick(4);
        ser_en = 1'b0;
        model_commit(1'b0);
        tick(8);
    endtask

    task automatic summary();
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: actual run still active, expected completion");
            summary();
        end
    end

    initial begin
        cur_req = "R1";
        tick(5);
        rst_n = 1'b1;
        tick(5);

        cur_req = "R2";
        hi_frame(32'b1010_1010, 8, 0);
        cur_req = "R3";
        hi_frame({1'b0, 5'b10110, 12'd446, 14'd9876}, 32, 0);

        cur_req = "R2";
        hi_frame(32'b1000_0101, 8, 0);

        cur_req = "R4";
        ch_frame({16'd4926, 16'd4238}, 32'hA5C3_5A3C, 32);
        cur_req = "R7";
        ch_frame({16'd5846, 16'd6205}, 32'h0, 32);
        cur_req = "R8";
        ch_frame({16'd0, 16'd5}, 32'hFFFF_FFFF, 32);
        cur_req = "R8";
        ch_frame({16'd15, 16'd16}, 32'h0, 32);

        cur_req = "R6";
        ch_frame({16'd1234, 16'd2345}, 32'h0, 31);
        cur_req = "R6";
        hi_frame({1'b1, 5'b0, 12'd77, 14'd55}, 32, 0);
        cur_req = "R6";
        hi_frame(32'b0101_0101, 8, 0);
        cur_req = "R6";
        hi_frame(32'b1_1111_1111, 9, 0);

        cur_req = "R5";
        hi_frame(32'b1001_0000, 8, 0);
        cur_req = "R5";
        ch_frame({16'h0, 16'd5950}, {16'h0, 16'd6638}, 16);
        cur_req = "R5";
        ch_frame({16'h0, 16'h8001}, {16'h0, 16'h7FFE}, 16);
        cur_req = "R6";
        ch_frame({16'h0, 16'd3000}, {16'h0, 16'd3001}, 17);
        cur_req = "R6";
        ch_frame({16'h0, 16'd3000}, {16'h0, 16'd3001}, 32);

        cur_req = "R9";
        hi_frame({1'b0, 5'b01001, 12'd4095, 14'd16383}, 32, 40);
        cur_req = "R7";
        hi_frame(32'b1000_1111, 8, 0);
        cur_req = "R4";
        ch_frame({16'd9322, 16'd7795}, 32'h1234_5678, 32);

        tick(10);
        summary();
    end
endmodule